// File: doc/BRIEF.md
# Converter Serial Status and Data Port

This block is the digital serial interface of an integrating analog-to-digital converter, seen from the converter side. The host drives one direction line (`rw_sel`), a serial clock (`dclk`) and a data input (`din`). The block drives one serial output (`dout`). When the direction line is high, the port sends a result frame. The first bit is the live end-of-conversion flag, then come the overrange and negative-polarity flags, then the conversion magnitude. Because the first bit is the live flag, a host can watch `dout` for readiness without a separate wire. When the direction line is low, the port takes in an 8-bit timing value. It hands that value to the conversion timebase as a one-cycle strobe when the line goes high again.

All host pins are asynchronous to the system clock `clk`. Each one passes through a two-flop synchronizer, and then edge detection. The result magnitude width is set by a parameter. A write that begins while end-of-conversion is high breaks the protocol. The block ignores such a write and sets a sticky error flag.

Top module: `cvt_serial_port`

## Requirements
- R1: A read frame is `MAG_W+3` bits long. Bit position 0 is the end-of-conversion flag. Position 1 is overrange, position 2 is polarity (1 = negative), and positions 3 onward carry the magnitude, most significant bit first. Once the frame is exhausted, `dout` stays 0 until the next read.
- R2: While `rw_sel` is high and no `dclk` falling edge has arrived since it went high, `dout` equals the live `conv_eoc`. While `rw_sel` is low, `dout` also equals `conv_eoc`.
- R3: In read mode, `dout` moves to the next frame bit only on a synchronized falling edge of `dclk`. A rising edge of `dclk` leaves `dout` unchanged.
- R4: The overrange, polarity and magnitude of a frame are captured when `rw_sel` rises. Changes on the result inputs after that point do not alter the frame being read.
- R5: While `rw_sel` is low, `din` is sampled on each synchronized rising edge of `dclk`. The first bit sampled becomes the most significant bit of the 8-bit load value.
- R6: On the rising edge of `rw_sel`, a write that received exactly 8 bits and started with `conv_eoc` low raises `load_stb` for exactly one `clk` cycle, with `load_value` holding the received byte. At every other time `load_stb` is 0 and `load_value` holds its value. A write with any other bit count produces no strobe.
- R7: If `rw_sel` falls while `conv_eoc` is high, `proto_err` is set and stays set until reset. That write produces no strobe and leaves `load_value` unchanged.
- R8: `eoc_pin` always equals `conv_eoc`.
- R9: After reset, `load_stb`, `proto_err` and `load_value` are 0, and `dout` follows `conv_eoc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rw_sel | input | 1 | Host direction line, asynchronous: 1 = read, 0 = write |
| dclk | input | 1 | Host serial clock, asynchronous |
| din | input | 1 | Host serial data in |
| dout | output | 1 | Serial data out: live EOC, then the latched frame |
| conv_eoc | input | 1 | End-of-conversion flag from the converter |
| conv_ovr | input | 1 | Overrange flag of the current result |
| conv_neg | input | 1 | Polarity of the current result, 1 = negative |
| conv_mag | input | MAG_W | Magnitude of the current result |
| eoc_pin | output | 1 | Dedicated end-of-conversion output |
| load_value | output | 8 | Timing value handed to the timebase |
| load_stb | output | 1 | One-cycle strobe that commits `load_value` |
| proto_err | output | 1 | Sticky flag for a write started while EOC was high |

## Verification
A wrong frame index in the read shifter shows on `dout` at the very next host clock rising edge. It appears as a frame bit that is shifted or repeated, or as a lost EOC bit, so a bit-by-bit comparison against the expected frame locates it to one position. A wrong bit counter or a missed error flag in the write path shows within about four system clocks of the `rw_sel` rise: a strobe appears that should not, a strobe fails to appear, or the byte is wrong. A frame that is not held correctly shows only when the result inputs change in the middle of a read, so the stimulus changes them deliberately at that point.

// File: rtl/cvt_port_pkg.sv
`timescale 1ns/1ps
package cvt_port_pkg;

    // Width of the timing value written by the host
    localparam int LOAD_W      = 8;
    // EOC, overrange and polarity lead each read frame
    localparam int STATUS_BITS = 3;

    // Synchronized view of one host pin
    typedef struct packed {
        logic level;
        logic rise;
        logic fall;
    } pin_ev_t;

    typedef enum logic {
        DIR_WRITE = 1'b0,
        DIR_READ  = 1'b1
    } port_dir_e;

    function automatic int frame_len(input int mag_w);
        return mag_w + STATUS_BITS;
    endfunction

    function automatic int cnt_w(input int max_val);
        return $clog2(max_val + 1);
    endfunction

endpackage

// File: rtl/cvt_edge_sync.sv
`timescale 1ns/1ps
module cvt_edge_sync
    import cvt_port_pkg::*;
#(
    parameter logic RST_VAL = 1'b0
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    pin,
    output pin_ev_t ev
);
    logic meta_q;
    logic stab_q;
    logic hist_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= RST_VAL;
            stab_q <= RST_VAL;
            hist_q <= RST_VAL;
        end else begin
            meta_q <= pin;
            stab_q <= meta_q;
            hist_q <= stab_q;
        end
    end

    always_comb begin
        ev.level = stab_q;
        ev.rise  = stab_q & ~hist_q;
        ev.fall  = ~stab_q & hist_q;
    end
endmodule

// File: rtl/cvt_rd_shifter.sv
`timescale 1ns/1ps
module cvt_rd_shifter
    import cvt_port_pkg::*;
#(
    parameter int MAG_W = 16
) (
    input  logic                                   clk,
    input  logic                                   rst,
    input  logic                                   rd_start,
    input  port_dir_e                              dir,
    input  logic                                   shift_evt,
    input  logic                                   eoc_live,
    input  logic                                   res_ovr,
    input  logic                                   res_neg,
    input  logic [MAG_W-1:0]                       res_mag,
    output logic                                   dout,
    output logic [cnt_w(frame_len(MAG_W))-1:0]     bit_idx
);
    localparam int FRAME_LEN = frame_len(MAG_W);
    localparam int IDX_W     = cnt_w(FRAME_LEN);
    localparam int BODY_W    = MAG_W + 2;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_LEN);

    logic [BODY_W-1:0] body_q;
    logic [IDX_W-1:0]  idx_q;
    logic [BODY_W-1:0] aligned;

    always_ff @(posedge clk) begin
        if (rst) begin
            body_q <= '0;
            idx_q  <= '0;
        end else if (rd_start) begin
            body_q <= {res_ovr, res_neg, res_mag};
            idx_q  <= '0;
        end else if (dir == DIR_WRITE) begin
            idx_q  <= '0;
        end else if (shift_evt && (idx_q != LAST_IDX)) begin
            idx_q  <= idx_q + 1'b1;
        end
    end

    // Position 1 maps to the top of the latched body
    always_comb begin
        aligned = body_q << (idx_q - IDX_W'(1));
        if (idx_q == '0) begin
            dout = eoc_live;
        end else if (idx_q < LAST_IDX) begin
            dout = aligned[BODY_W-1];
        end else begin
            dout = 1'b0;
        end
    end

    assign bit_idx = idx_q;
endmodule

// File: rtl/cvt_wr_capture.sv
`timescale 1ns/1ps
module cvt_wr_capture
    import cvt_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_start,
    input  logic              wr_commit,
    input  port_dir_e         dir,
    input  logic              bit_evt,
    input  logic              din_bit,
    input  logic              eoc_live,
    output logic [LOAD_W-1:0] load_value,
    output logic              load_stb,
    output logic              proto_err
);
    localparam int CNT_MAX = LOAD_W + 1;
    localparam int CNT_W   = cnt_w(CNT_MAX);
    localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(CNT_MAX);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(LOAD_W);

    logic [LOAD_W-1:0] shreg_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              bad_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg_q    <= '0;
            cnt_q      <= '0;
            bad_q      <= 1'b0;
            load_value <= '0;
            load_stb   <= 1'b0;
            proto_err  <= 1'b0;
        end else begin
            load_stb <= 1'b0;
            if (wr_start) begin
                shreg_q <= '0;
                cnt_q   <= '0;
                bad_q   <= eoc_live;
                if (eoc_live) begin
                    proto_err <= 1'b1;
                end
            end else if ((dir == DIR_WRITE) && bit_evt) begin
                shreg_q <= {shreg_q[LOAD_W-2:0], din_bit};
                if (cnt_q != CNT_SAT) begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
            if (wr_commit && !bad_q && (cnt_q == CNT_FULL)) begin
                load_value <= shreg_q;
                load_stb   <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/cvt_serial_port.sv
`timescale 1ns/1ps
module cvt_serial_port
    import cvt_port_pkg::*;
#(
    parameter int MAG_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rw_sel,
    input  logic              dclk,
    input  logic              din,
    output logic              dout,
    input  logic              conv_eoc,
    input  logic              conv_ovr,
    input  logic              conv_neg,
    input  logic [MAG_W-1:0]  conv_mag,
    output logic              eoc_pin,
    output logic [LOAD_W-1:0] load_value,
    output logic              load_stb,
    output logic              proto_err
);
    localparam int NSYNC = 3;
    localparam int IDX_W = cnt_w(frame_len(MAG_W));
    // Index 0: direction, 1: serial clock, 2: serial data
    localparam logic [NSYNC-1:0] SYNC_RST = 3'b001;

    logic [NSYNC-1:0] host_pins;
    pin_ev_t          ev [NSYNC];

    assign host_pins = {din, dclk, rw_sel};

    for (genvar g = 0; g < NSYNC; g++) begin : g_sync
        cvt_edge_sync #(
            .RST_VAL (SYNC_RST[g])
        ) u_sync (
            .clk (clk),
            .rst (rst),
            .pin (host_pins[g]),
            .ev  (ev[g])
        );
    end

    logic             rw_rise;
    logic             rw_fall;
    logic             rw_level;
    port_dir_e        dir;
    logic [IDX_W-1:0] rd_idx;
    logic             unused_edges;

    assign rw_rise  = ev[0].rise;
    assign rw_fall  = ev[0].fall;
    assign rw_level = ev[0].level;
    assign dir      = rw_level ? DIR_READ : DIR_WRITE;
    assign unused_edges = ^{ev[1].level, ev[2].rise, ev[2].fall};

    cvt_rd_shifter #(
        .MAG_W (MAG_W)
    ) u_rd (
        .clk       (clk),
        .rst       (rst),
        .rd_start  (rw_rise),
        .dir       (dir),
        .shift_evt (ev[1].fall),
        .eoc_live  (conv_eoc),
        .res_ovr   (conv_ovr),
        .res_neg   (conv_neg),
        .res_mag   (conv_mag),
        .dout      (dout),
        .bit_idx   (rd_idx)
    );

    cvt_wr_capture u_wr (
        .clk        (clk),
        .rst        (rst),
        .wr_start   (rw_fall),
        .wr_commit  (rw_rise),
        .dir        (dir),
        .bit_evt    (ev[1].rise),
        .din_bit    (ev[2].level),
        .eoc_live   (conv_eoc),
        .load_value (load_value),
        .load_stb   (load_stb),
        .proto_err  (proto_err)
    );

    assign eoc_pin = conv_eoc;
endmodule

// File: rtl/cvt_serial_port_chk.sv
`timescale 1ns/1ps
module cvt_serial_port_chk
    import cvt_port_pkg::*;
#(
    parameter int MAG_W = 16
) (
    input logic                                clk,
    input logic                                rst,
    input logic                                rw_rise,
    input logic                                rw_fall,
    input logic                                rw_level,
    input logic                                conv_eoc,
    input logic [cnt_w(frame_len(MAG_W))-1:0]  bit_idx,
    input logic [LOAD_W-1:0]                   load_value,
    input logic                                load_stb,
    input logic                                proto_err
);
    localparam int FRAME_LEN = frame_len(MAG_W);

    // R6
    stb_single_chk: assert property (@(posedge clk) disable iff (rst)
        load_stb |=> !load_stb);

    // R6
    stb_cause_chk: assert property (@(posedge clk) disable iff (rst)
        load_stb |-> $past(rw_rise));

    // R6
    value_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !load_stb |-> $stable(load_value));

    // R7
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        proto_err |=> proto_err);

    // R7
    err_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(proto_err) |-> $past(rw_fall && conv_eoc));

    // R1
    idx_bound_chk: assert property (@(posedge clk) disable iff (rst)
        bit_idx <= FRAME_LEN);

    // R3
    idx_step_chk: assert property (@(posedge clk) disable iff (rst)
        (rw_level && !rw_rise) |=>
            (bit_idx == $past(bit_idx) || bit_idx == $past(bit_idx) + 1'b1));
endmodule

bind cvt_serial_port cvt_serial_port_chk #(.MAG_W(MAG_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .rw_rise    (rw_rise),
    .rw_fall    (rw_fall),
    .rw_level   (rw_level),
    .conv_eoc   (conv_eoc),
    .bit_idx    (rd_idx),
    .load_value (load_value),
    .load_stb   (load_stb),
    .proto_err  (proto_err)
);

// File: tb/cvt_serial_port_bench.sv
`timescale 1ns/1ps
module cvt_serial_port_bench;
    localparam int MAG_W = 16;
    localparam int FLEN  = MAG_W + 3;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             rw_sel = 1'b1;
    logic             dclk = 1'b0;
    logic             din = 1'b0;
    logic             dout;
    logic             conv_eoc = 1'b0;
    logic             conv_ovr = 1'b0;
    logic             conv_neg = 1'b0;
    logic [MAG_W-1:0] conv_mag = '0;
    logic             eoc_pin;
    logic [7:0]       load_value;
    logic             load_stb;
    logic             proto_err;

    int  checks = 0;
    int  fails  = 0;
    int  cycles = 0;
    bit  rd_mon_en = 1'b0;
    bit  exp_bits[$];
    logic [7:0] exp_loads[$];

    always #10 clk = ~clk;

    cvt_serial_port #(.MAG_W(MAG_W)) u_cvt_serial_port (
        .clk        (clk),
        .rst        (rst),
        .rw_sel     (rw_sel),
        .dclk       (dclk),
        .din        (din),
        .dout       (dout),
        .conv_eoc   (conv_eoc),
        .conv_ovr   (conv_ovr),
        .conv_neg   (conv_neg),
        .conv_mag   (conv_mag),
        .eoc_pin    (eoc_pin),
        .load_value (load_value),
        .load_stb   (load_stb),
        .proto_err  (proto_err)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Read monitor: compare each frame bit at the host sampling edge
    always @(posedge dclk) begin
        if (rd_mon_en) begin
            if (exp_bits.size() == 0) begin
                chk(1'b0, "R1 extra bit", 32'(dout), 32'hx);
            end else begin
                bit e;
                e = exp_bits.pop_front();
                chk(dout === e, "R1/R4 frame bit", 32'(dout), 32'(e));
            end
        end
    end

    // Write monitor: every strobe must match the next expected load
    always @(negedge clk) begin
        if (!rst && load_stb === 1'b1) begin
            if (exp_loads.size() == 0) begin
                chk(1'b0, "R6/R7 unexpected strobe", 32'(load_value), 32'h0);
            end else begin
                logic [7:0] e;
                e = exp_loads.pop_front();
                chk(load_value === e, "R5/R6 load value", 32'(load_value), 32'(e));
            end
        end
    end

    task automatic host_pulse();
        wait_clk(8);
        dclk = 1'b1;
        wait_clk(8);
        dclk = 1'b0;
    endtask

    task automatic do_read(input bit eoc_v, input bit ovr, input bit neg,
                           input logic [MAG_W-1:0] mag, input bit disturb);
        conv_eoc = 1'b0;
        rw_sel   = 1'b0;
        wait_clk(6);
        conv_ovr = ovr;
        conv_neg = neg;
        conv_mag = mag;
        rw_sel   = 1'b1;
        wait_clk(6);
        conv_eoc = eoc_v;
        exp_bits.push_back(eoc_v);
        exp_bits.push_back(ovr);
        exp_bits.push_back(neg);
        for (int i = MAG_W - 1; i >= 0; i--) exp_bits.push_back(mag[i]);
        exp_bits.push_back(1'b0);
        rd_mon_en = 1'b1;
        // R3: a rising host edge alone does not move the frame
        wait_clk(8);
        dclk = 1'b1;
        wait_clk(8);
        chk(dout === eoc_v, "R3 rise holds bit", 32'(dout), 32'(eoc_v));
        dclk = 1'b0;
        for (int k = 1; k <= FLEN; k++) begin
            if (disturb && k == 4) begin
                conv_ovr = ~ovr;
                conv_neg = ~neg;
                conv_mag = ~mag;
            end
            host_pulse();
        end
        wait_clk(8);
        rd_mon_en = 1'b0;
        chk(exp_bits.size() == 0, "R1 frame length", 32'(exp_bits.size()), 32'h0);
        chk(dout === 1'b0, "R1 idle after frame", 32'(dout), 32'h0);
    endtask

    task automatic do_write(input logic [15:0] bits, input int nbits, input bit eoc_v);
        conv_eoc = eoc_v;
        wait_clk(2);
        rw_sel = 1'b0;
        wait_clk(6);
        conv_eoc = 1'b0;
        wait_clk(1);
        chk(dout === 1'b0, "R2 write mode dout", 32'(dout), 32'h0);
        conv_eoc = 1'b1;
        wait_clk(1);
        chk(dout === 1'b1, "R2 write mode dout", 32'(dout), 32'h1);
        conv_eoc = 1'b0;
        for (int i = nbits - 1; i >= 0; i--) begin
            din = bits[i];
            wait_clk(4);
            dclk = 1'b1;
            wait_clk(8);
            dclk = 1'b0;
            wait_clk(4);
        end
        rw_sel = 1'b1;
        wait_clk(10);
    endtask

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=<150000", cycles);
            $display("[TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

    initial begin
        wait_clk(5);
        rst = 1'b0;
        wait_clk(5);
        // R9 reset state
        chk(load_stb === 1'b0, "R9 strobe", 32'(load_stb), 32'h0);
        chk(proto_err === 1'b0, "R9 error flag", 32'(proto_err), 32'h0);
        chk(load_value === 8'h00, "R9 load value", 32'(load_value), 32'h0);
        chk(dout === 1'b0, "R9 dout", 32'(dout), 32'h0);
        // R8 and R2 polling
        conv_eoc = 1'b1;
        wait_clk(1);
        chk(eoc_pin === 1'b1, "R8 eoc pin", 32'(eoc_pin), 32'h1);
        chk(dout === 1'b1, "R2 poll high", 32'(dout), 32'h1);
        conv_eoc = 1'b0;
        wait_clk(1);
        chk(eoc_pin === 1'b0, "R8 eoc pin", 32'(eoc_pin), 32'h0);
        chk(dout === 1'b0, "R2 poll low", 32'(dout), 32'h0);

        // R1 frames under several patterns, R4 with mid-read disturbance
        do_read(1'b1, 1'b0, 1'b0, 16'hA5C3, 1'b0);
        do_read(1'b0, 1'b1, 1'b1, 16'h0001, 1'b0);
        do_read(1'b1, 1'b0, 1'b1, 16'h8000, 1'b1);
        do_read(1'b1, 1'b1, 1'b0, 16'h0000, 1'b1);

        // R5/R6 valid writes
        exp_loads.push_back(8'hA5);
        do_write(16'h00A5, 8, 1'b0);
        exp_loads.push_back(8'h3C);
        do_write(16'h003C, 8, 1'b0);
        // R6 wrong bit counts: no strobe
        do_write(16'h0015, 5, 1'b0);
        do_write(16'h01FF, 9, 1'b0);
        chk(load_value === 8'h3C, "R6 value kept", 32'(load_value), 32'h3C);
        chk(proto_err === 1'b0, "R7 no error yet", 32'(proto_err), 32'h0);
        // R7 write started with EOC high
        do_write(16'h005A, 8, 1'b1);
        chk(proto_err === 1'b1, "R7 error set", 32'(proto_err), 32'h1);
        chk(load_value === 8'h3C, "R7 load ignored", 32'(load_value), 32'h3C);
        exp_loads.push_back(8'h77);
        do_write(16'h0077, 8, 1'b0);
        chk(proto_err === 1'b1, "R7 error sticky", 32'(proto_err), 32'h1);
        chk(exp_loads.size() == 0, "R6 missing strobe", 32'(exp_loads.size()), 32'h0);

        wait_clk(10);
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end
endmodule